// File: doc/BRIEF.md
# Test Output Clock Selector

This block drives one test pin of a frequency synthesizer. A 3-bit select code picks what appears on the pin: a fixed high or low level, the serial shift-register bit, the reference divided by 16, the feedback (M) divider output halved, the main synthesized output, or that output divided by 4. One code moves the M and N dividers off the VCO and onto the serial shift clock, so the divide chain can be checked at low speed. The block also produces the main output level (`fout`) from the N divider.

All sources are modelled inside a single fast system clock domain. Each one-cycle pulse on `vco_tick`, `ref_tick` or `sclk_tick` stands for one edge of that source clock, rising or falling, and the first pulse after a clear is a rising edge. Divided clocks are flop levels that toggle on counted ticks. Only the divide chain and the selection logic are built here.

Top module: `testclk_sel`

## Requirements
- R1: After reset, `test_out` and `fout` are both low.
- R2: Code 3'b001 holds `test_out` high and code 3'b101 holds it low, whatever ticks arrive.
- R3: Under code 3'b000, `test_out` repeats `sr_bit` one system clock later.
- R4: Under code 3'b010, `test_out` is a level that starts low after a clear and toggles once every 16 `ref_tick` pulses.
- R5: The M divider counts only rising source edges, which are the odd-numbered ticks after a clear. It makes a terminal-count pulse every `m_val` rising edges, and a halving flop toggles on that pulse. Under code 3'b011 this flop drives `test_out`, so its first toggle comes on tick 2*M-1 and later toggles come every 2*M ticks.
- R6: `fout` toggles once every 2^`n_code` divider ticks (codes 00, 01, 10 and 11 give 1, 2, 4 and 8), so its high and low times are equal. Under code 3'b100, `test_out` repeats `fout` one system clock later.
- R7: Under code 3'b110, the M and N dividers count `sclk_tick` in place of `vco_tick`. `vco_tick` then has no effect on either divider, and `test_out` shows the halved M divider output.
- R8: Under code 3'b111, `test_out` toggles once for every four toggles of `fout`.
- R9: A new select code shows on `test_out` at the next clock edge. Whenever the code differs from the previous cycle's code, every divider count and level is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vco_tick | input | 1 | One pulse per VCO edge |
| ref_tick | input | 1 | One pulse per reference oscillator edge |
| sclk_tick | input | 1 | One pulse per serial shift clock edge |
| sr_bit | input | 1 | Serial shift-register output bit |
| m_val | input | 9 | Feedback divide value M |
| n_code | input | 2 | Output divider code |
| tsel | input | 3 | Test-select code |
| fout | output | 1 | Main output level from the N divider |
| test_out | output | 1 | Test pin level |

## Verification
A divider level moves on the clock edge that samples its tick. `test_out` registers that level one edge later, and the `fout`-divided-by-4 path adds one more edge for its edge detector. The bench holds every tick high for one cycle and low for the next, then samples at the falling edge. That puts a settled `test_out` or `fout` in front of each check, with one extra idle cycle before the divide-by-4 checks. A mode change is followed by two idle cycles, one for the clear and one for the output register. The expected toggle points are counted in ticks straight from the requirements, for example tick 2*M-1 for the M path and tick 16 for the reference path.

// File: rtl/testclk_pkg.sv
// Shared select-code type for the test output selector.
// Assumes a 3-bit select; each code value is fixed by the pin behaviour.
package testclk_pkg;

    typedef enum logic [2:0] {
        SEL_SHIFT  = 3'b000,
        SEL_HIGH   = 3'b001,
        SEL_REF16  = 3'b010,
        SEL_MHALF  = 3'b011,
        SEL_FOUT   = 3'b100,
        SEL_LOW    = 3'b101,
        SEL_SCLK_M = 3'b110,
        SEL_FOUT4  = 3'b111
    } tsel_e;

endpackage

// File: rtl/edge_div.sv
// Toggle divider: the output level flips after every `half` enabled ticks.
// Assumes half >= 1; if half shrinks mid-count the counter wraps at once.
module edge_div #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] half,
    output logic             lvl
);
    localparam logic [CNT_W-1:0] ONE = 1;

    logic [CNT_W-1:0] cnt;
    logic             wrap;

    // Terminal point of the current half period.
    assign wrap = (cnt >= half - ONE);

    // Count ticks and toggle the level at each half-period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
            lvl <= 1'b0;
        end else if (tick) begin
            if (wrap) begin
                cnt <= '0;
                lvl <= ~lvl;
            end else begin
                cnt <= cnt + ONE;
            end
        end
    end

endmodule

// File: rtl/m_divider.sv
// Feedback divider: a down-counter reloaded with M-1 that counts rising
// source edges only, with a halving flop toggled by its terminal pulse.
// Assumes the first tick after a clear is a rising edge; M of 0 acts as 1.
module m_divider #(
    parameter int M_W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           tick,
    input  logic [M_W-1:0] m_val,
    output logic           half_lvl
);
    localparam logic [M_W-1:0] ONE = 1;

    logic           phase;
    logic [M_W-1:0] cnt;
    logic [M_W-1:0] reload;
    logic           rise;
    logic           tc_pulse;

    // Reload value, guarding against a zero divide value.
    assign reload   = (m_val == '0) ? '0 : m_val - ONE;
    // A tick seen while the modelled source level is low is a rising edge.
    assign rise     = tick & ~phase;
    // One-cycle terminal-count pulse.
    assign tc_pulse = rise & (cnt == '0);

    // Track source level, count rising edges, halve the terminal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase    <= 1'b0;
            cnt      <= reload;
            half_lvl <= 1'b0;
        end else begin
            if (tick) begin
                phase <= ~phase;
            end
            if (rise) begin
                cnt <= tc_pulse ? reload : cnt - ONE;
            end
            if (tc_pulse) begin
                half_lvl <= ~half_lvl;
            end
        end
    end

endmodule

// File: rtl/testclk_sel.sv
// Test pin selector with its divide chain: reference /16, M divider with
// halving stage, N output divider and an fout /4 stage, all as enable-driven
// levels in the system clock domain. Assumes tick inputs are one-cycle pulses
// marking source edges. A select change clears every divider.
module testclk_sel
    import testclk_pkg::*;
#(
    parameter int M_W      = 9,
    parameter int N_W      = 2,
    parameter int REF_HALF = 16,
    parameter int F4_HALF  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vco_tick,
    input  logic           ref_tick,
    input  logic           sclk_tick,
    input  logic           sr_bit,
    input  logic [M_W-1:0] m_val,
    input  logic [N_W-1:0] n_code,
    input  logic [2:0]     tsel,
    output logic           fout,
    output logic           test_out
);
    localparam int REF_CW = $clog2(REF_HALF) + 1;
    localparam int N_CW   = 1 << N_W;
    localparam int F4_CW  = $clog2(F4_HALF) + 1;

    logic [2:0]      tsel_q;
    logic            clr;
    logic            div_tick;
    logic            ref_lvl;
    logic            m_half;
    logic            f4_lvl;
    logic            fout_prev;
    logic            fout_edge;
    logic [N_CW-1:0] n_half;

    // Remember the previous select code to detect a change.
    always_ff @(posedge clk) begin
        if (!rst_n) tsel_q <= SEL_SHIFT;
        else        tsel_q <= tsel;
    end

    assign clr      = (tsel != tsel_q);
    // The divider clock source: shift clock in the low-speed test code.
    assign div_tick = (tsel == SEL_SCLK_M) ? sclk_tick : vco_tick;
    // N code maps to a power-of-two half period.
    assign n_half   = N_CW'(1) << n_code;

    edge_div #(.CNT_W(REF_CW)) u_ref_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .tick  (ref_tick),
        .half  (REF_CW'(REF_HALF)),
        .lvl   (ref_lvl)
    );

    m_divider #(.M_W(M_W)) u_m_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .tick     (div_tick),
        .m_val    (m_val),
        .half_lvl (m_half)
    );

    edge_div #(.CNT_W(N_CW)) u_n_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .tick  (div_tick),
        .half  (n_half),
        .lvl   (fout)
    );

    // Delayed copy of fout for toggle detection feeding the /4 stage.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) fout_prev <= 1'b0;
        else               fout_prev <= fout;
    end

    assign fout_edge = fout ^ fout_prev;

    edge_div #(.CNT_W(F4_CW)) u_f4_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .tick  (fout_edge),
        .half  (F4_CW'(F4_HALF)),
        .lvl   (f4_lvl)
    );

    // Register the selected source onto the test pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_out <= 1'b0;
        end else begin
            case (tsel_e'(tsel))
                SEL_SHIFT:  test_out <= sr_bit;
                SEL_HIGH:   test_out <= 1'b1;
                SEL_REF16:  test_out <= ref_lvl;
                SEL_MHALF:  test_out <= m_half;
                SEL_FOUT:   test_out <= fout;
                SEL_LOW:    test_out <= 1'b0;
                SEL_SCLK_M: test_out <= m_half;
                SEL_FOUT4:  test_out <= f4_lvl;
                default:    test_out <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/testclk_sel_chk.sv
// Port-level checker for testclk_sel, bound to every instance.
// Assumes the synchronous reset; an age counter keeps $past inside the
// cycles since reset.
module testclk_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] tsel,
    input logic       sr_bit,
    input logic       sclk_tick,
    input logic       fout,
    input logic       test_out
);
    logic [1:0] age;

    // Count non-reset edges, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    p_const_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) && ($past(tsel) == 3'b001) |-> test_out);

    p_const_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) && ($past(tsel) == 3'b101) |-> !test_out);

    p_shift_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) && ($past(tsel) == 3'b000) |-> (test_out == $past(sr_bit)));

    p_fout_echo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) && ($past(tsel) == 3'b100) |-> (test_out == $past(fout)));

    p_sclk_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) && ($past(tsel) == 3'b110) && ($past(tsel, 2) == 3'b110)
        && !$past(sclk_tick) |-> $stable(fout));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) && ($past(tsel) != $past(tsel, 2)) |-> !fout);

endmodule

bind testclk_sel testclk_sel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tsel      (tsel),
    .sr_bit    (sr_bit),
    .sclk_tick (sclk_tick),
    .fout      (fout),
    .test_out  (test_out)
);

// File: tb/testclk_sel_tb.sv
module testclk_sel_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vco_tick = 1'b0;
    logic       ref_tick = 1'b0;
    logic       sclk_tick = 1'b0;
    logic       sr_bit = 1'b0;
    logic [8:0] m_val = 9'd3;
    logic [1:0] n_code = 2'd0;
    logic [2:0] tsel = 3'b000;
    logic       fout;
    logic       test_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    testclk_sel u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .vco_tick  (vco_tick),
        .ref_tick  (ref_tick),
        .sclk_tick (sclk_tick),
        .sr_bit    (sr_bit),
        .m_val     (m_val),
        .n_code    (n_code),
        .tsel      (tsel),
        .fout      (fout),
        .test_out  (test_out)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // src 0 = vco, 1 = ref, 2 = shift clock; one tick high, one cycle low.
    task automatic pulse(input int src, input int k);
        for (int i = 0; i < k; i++) begin
            case (src)
                0:       vco_tick = 1'b1;
                1:       ref_tick = 1'b1;
                default: sclk_tick = 1'b1;
            endcase
            @(negedge clk);
            vco_tick = 1'b0; ref_tick = 1'b0; sclk_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic set_mode(input logic [2:0] code);
        tsel = code;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", "test_out after reset", test_out, 1'b0);
        chk("R1", "fout after reset", fout, 1'b0);
    endtask

    task automatic t_const;
        set_mode(3'b001);
        pulse(0, 3); pulse(1, 3);
        chk("R2", "code 001 high", test_out, 1'b1);
        set_mode(3'b101);
        pulse(0, 3); pulse(2, 3);
        chk("R2", "code 101 low", test_out, 1'b0);
    endtask

    task automatic t_shift;
        set_mode(3'b000);
        sr_bit = 1'b1; @(negedge clk);
        chk("R3", "shift bit high", test_out, 1'b1);
        sr_bit = 1'b0; @(negedge clk);
        chk("R3", "shift bit low", test_out, 1'b0);
    endtask

    task automatic t_ref;
        set_mode(3'b010);
        pulse(1, 15); chk("R4", "ref tick 15", test_out, 1'b0);
        pulse(1, 1);  chk("R4", "ref tick 16", test_out, 1'b1);
        pulse(1, 15); chk("R4", "ref tick 31", test_out, 1'b1);
        pulse(1, 1);  chk("R4", "ref tick 32", test_out, 1'b0);
    endtask

    task automatic t_mhalf;
        m_val = 9'd3;
        set_mode(3'b011);
        pulse(0, 4); chk("R5", "M=3 tick 4", test_out, 1'b0);
        pulse(0, 1); chk("R5", "M=3 tick 5", test_out, 1'b1);
        pulse(0, 5); chk("R5", "M=3 tick 10", test_out, 1'b1);
        pulse(0, 1); chk("R5", "M=3 tick 11", test_out, 1'b0);
    endtask

    task automatic t_nout;
        n_code = 2'd2;
        set_mode(3'b100);
        pulse(0, 3); chk("R6", "N=4 fout tick 3", fout, 1'b0);
        pulse(0, 1); chk("R6", "N=4 fout tick 4", fout, 1'b1);
        chk("R6", "N=4 test_out tick 4", test_out, 1'b1);
        pulse(0, 4); chk("R6", "N=4 fout tick 8", fout, 1'b0);
        n_code = 2'd0;
        set_mode(3'b001); set_mode(3'b100);
        pulse(0, 1); chk("R6", "N=1 fout tick 1", fout, 1'b1);
        pulse(0, 1); chk("R6", "N=1 fout tick 2", fout, 1'b0);
        n_code = 2'd3;
        set_mode(3'b001); set_mode(3'b100);
        pulse(0, 7); chk("R6", "N=8 fout tick 7", fout, 1'b0);
        pulse(0, 1); chk("R6", "N=8 fout tick 8", fout, 1'b1);
        pulse(0, 7); chk("R6", "N=8 fout tick 15", fout, 1'b1);
        pulse(0, 1); chk("R6", "N=8 fout tick 16", fout, 1'b0);
    endtask

    task automatic t_sclk;
        m_val = 9'd2; n_code = 2'd1;
        set_mode(3'b110);
        pulse(0, 10);
        chk("R7", "vco ignored test_out", test_out, 1'b0);
        chk("R7", "vco ignored fout", fout, 1'b0);
        pulse(2, 2);
        chk("R7", "sclk tick 2 test_out", test_out, 1'b0);
        chk("R7", "sclk tick 2 fout", fout, 1'b1);
        pulse(2, 1);
        chk("R7", "sclk tick 3 test_out", test_out, 1'b1);
    endtask

    task automatic t_div4;
        n_code = 2'd1;
        set_mode(3'b111);
        pulse(0, 7); @(negedge clk); chk("R8", "fout/4 tick 7", test_out, 1'b0);
        pulse(0, 1); @(negedge clk); chk("R8", "fout/4 tick 8", test_out, 1'b1);
        pulse(0, 7); @(negedge clk); chk("R8", "fout/4 tick 15", test_out, 1'b1);
        pulse(0, 1); @(negedge clk); chk("R8", "fout/4 tick 16", test_out, 1'b0);
    endtask

    task automatic t_clear;
        set_mode(3'b010);
        pulse(1, 10);
        set_mode(3'b001);
        set_mode(3'b010);
        pulse(1, 15); chk("R9", "cleared ref count tick 15", test_out, 1'b0);
        pulse(1, 1);  chk("R9", "cleared ref count tick 16", test_out, 1'b1);
        tsel = 3'b101; @(negedge clk);
        chk("R9", "next edge low code", test_out, 1'b0);
        tsel = 3'b001; @(negedge clk);
        chk("R9", "next edge high code", test_out, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_const;
        t_shift;
        t_ref;
        t_mhalf;
        t_nout;
        t_sclk;
        t_div4;
        t_clear;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule